// File: doc/BRIEF.md
# Spilling Hardware Stack Register

This block presents a whole stack to the processor as a single register port. A write to the port pushes a word and a read pops the newest word. There is no visible pointer and no way to address entries below the top. The newest entries sit in a small flip-flop buffer, so pushes and pops that stay inside that buffer finish in the cycle they are presented and make no memory access.

When a push arrives and the buffer is full, the block first writes the oldest buffered word to backing memory, at a spill address that climbs from a base address. When the buffer falls below a low-water mark and spilled words exist, the most recently spilled word is read back and placed under the buffered entries. A `ready` output tells the core whether the presented push or pop can complete now. The core holds its request while `ready` is low. Only one memory transaction is in flight at a time. Popping a completely empty stack returns zero and raises a sticky underflow flag.

Top module: `spill_stack`

## Requirements
- R1: Popped words come out in last-in, first-out order. `pop_data` is valid in the cycle where `pop_valid` and `ready` are both high, which is the cycle in which the pop completes.
- R2: While the stack holds no more than DEPTH words, pushes and pops raise no memory request (`mem_req` stays 0).
- R3: A push that finds the buffer full causes a memory write (`mem_we`=1) of the oldest buffered word to address SPILL_BASE + (number of words currently spilled). Successive spills use ascending addresses.
- R4: When fewer than LOW_MARK words are buffered and spilled words exist, a memory read (`mem_we`=0) is issued at the address of the most recently spilled word that is still unread. The returned word becomes the oldest buffered entry, so later pops keep LIFO order.
- R5: `ready` is 0 in every cycle that `mem_req` is 1. With no transaction outstanding, `ready` is 1 except for two cases: a push with a full buffer, and a pop with an empty buffer while spilled words exist.
- R6: A pop with no buffered and no spilled words completes at once with `pop_data` = 0. `underflow` is 1 from the next cycle on and stays 1 until reset.
- R7: After reset, the following hold: `underflow`=0, `mem_req`=0, `ready`=1 with no request presented, and `pop_data`=0.
- R8: When `push_valid` and `pop_valid` are both high, only the push is performed and the pop is ignored.
- R9: `mem_req`, `mem_we` and `mem_addr` are held stable from the start of a transaction until the cycle in which `mem_ack` is high. `mem_rdata` is taken in that same cycle. A new transaction starts only after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Core requests a push |
| push_data | input | DATA_W | Word to push |
| pop_valid | input | 1 | Core requests a pop |
| pop_data | output | DATA_W | Top word, or 0 when nothing is buffered |
| ready | output | 1 | The presented request completes this cycle |
| underflow | output | 1 | Sticky: a pop found the stack empty |
| mem_req | output | 1 | Memory transaction outstanding |
| mem_we | output | 1 | 1 = spill write, 0 = refill read |
| mem_addr | output | ADDR_W | Word address of the transaction |
| mem_wdata | output | DATA_W | Spilled word |
| mem_ack | input | 1 | Memory completes the transaction this cycle |
| mem_rdata | input | DATA_W | Refill word, valid with `mem_ack` |

## Verification
Timing of each result:
- `pop_data` and `ready` are combinational from the buffer state, so the bench reads them 1 ns before the rising edge at which the handshake takes place.
- `underflow` turns on one cycle after the empty pop, and the reference model sets its own flag only after that edge.
- A spill or refill appears on `mem_req` one cycle after the cycle that decides it.
- A refilled word is poppable from the cycle after `mem_ack`. The bench's memory model answers two cycles after it first sees a request and checks addresses as each request appears.

Comparisons:
- Every clock, the model compares `underflow` and the busy stall.
- At each accepted pop, the model compares `pop_data` with the back of its queue.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
    typedef enum logic [2:0] {
        BUF_HOLD,
        BUF_PUSH,
        BUF_POP,
        BUF_DROP_OLD,
        BUF_ADD_OLD
    } buf_op_e;
endpackage

// File: rtl/stk_buf.sv
`timescale 1ns/1ps
module stk_buf
    import stk_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  buf_op_e                        op,
    input  logic [W-1:0]                   din,
    output logic [W-1:0]                   top,
    output logic [W-1:0]                   oldest,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [CW-1:0]           cnt;
    } buf_st_t;

    buf_st_t q, d;

    always_comb begin
        d = q;
        case (op)
            BUF_PUSH: begin
                for (int i = 0; i < DEPTH; i++)
                    if (CW'(i) == q.cnt) d.ent[i] = din;
                d.cnt = q.cnt + 1'b1;
            end
            BUF_POP: d.cnt = q.cnt - 1'b1;
            BUF_DROP_OLD: begin
                for (int i = 0; i < DEPTH - 1; i++) d.ent[i] = q.ent[i+1];
                d.cnt = q.cnt - 1'b1;
            end
            BUF_ADD_OLD: begin
                for (int i = 1; i < DEPTH; i++) d.ent[i] = q.ent[i-1];
                d.ent[0] = din;
                d.cnt    = q.cnt + 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (CW'(i + 1) == q.cnt) top = q.ent[i];
    end

    assign oldest = q.ent[0];
    assign count  = q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/stk_memport.sv
`timescale 1ns/1ps
module stk_memport #(
    parameter int W  = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_wr,
    input  logic          start_rd,
    input  logic [AW-1:0] addr_in,
    input  logic [W-1:0]  wdata_in,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata
);
    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [W-1:0]  wdata;
    } port_st_t;

    port_st_t q, d;

    always_comb begin
        d = q;
        if (q.req) begin
            if (mem_ack) d.req = 1'b0;
        end else if (start_wr || start_rd) begin
            d.req   = 1'b1;
            d.we    = start_wr;
            d.addr  = addr_in;
            d.wdata = start_wr ? wdata_in : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req   = q.req;
    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
endmodule

// File: rtl/spill_stack.sv
`timescale 1ns/1ps
module spill_stack
    import stk_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int DEPTH      = 4,
    parameter int LOW_MARK   = 2,
    parameter int ADDR_W     = 8,
    parameter int SPILL_BASE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic              ready,
    output logic              underflow,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int                 CNT_W  = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0]   FULL   = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0]   LOWM   = CNT_W'(LOW_MARK);
    localparam logic [ADDR_W-1:0]  BASE_A = ADDR_W'(SPILL_BASE);

    typedef struct packed {
        logic [ADDR_W-1:0] spilled;
        logic              uflow;
    } ctl_t;

    ctl_t              q, d;
    buf_op_e           op;
    logic [DATA_W-1:0] bin, top, oldest;
    logic [CNT_W-1:0]  cnt;
    logic              start_wr, start_rd, busy, have_spill;
    logic [ADDR_W-1:0] req_addr;

    assign busy       = mem_req;
    assign have_spill = (q.spilled != '0);

    always_comb begin
        d        = q;
        op       = BUF_HOLD;
        bin      = '0;
        start_wr = 1'b0;
        start_rd = 1'b0;
        req_addr = '0;
        ready    = 1'b0;

        if (!busy) begin
            if (push_valid)     ready = (cnt != FULL);
            else if (pop_valid) ready = (cnt != '0) || !have_spill;
            else                ready = 1'b1;
        end

        if (ready && push_valid) begin
            op  = BUF_PUSH;
            bin = push_data;
        end else if (ready && pop_valid) begin
            if (cnt != '0) op = BUF_POP;
            else           d.uflow = 1'b1;
        end else if (!busy && push_valid && cnt == FULL) begin
            op        = BUF_DROP_OLD;
            start_wr  = 1'b1;
            req_addr  = BASE_A + q.spilled;
            d.spilled = q.spilled + 1'b1;
        end

        if (!busy && !start_wr && have_spill && cnt < LOWM) begin
            start_rd  = 1'b1;
            req_addr  = BASE_A + q.spilled - 1'b1;
            d.spilled = q.spilled - 1'b1;
        end

        if (busy && mem_ack && !mem_we) begin
            op  = BUF_ADD_OLD;
            bin = mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    stk_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .din    (bin),
        .top    (top),
        .oldest (oldest),
        .count  (cnt)
    );

    stk_memport #(.W(DATA_W), .AW(ADDR_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .addr_in   (req_addr),
        .wdata_in  (oldest),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign pop_data  = top;
    assign underflow = q.uflow;
endmodule

// File: rtl/stk_chk.sv
`timescale 1ns/1ps
module stk_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              pop_valid,
    input logic              ready,
    input logic              underflow,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    a_r5_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ready);

    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r9_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    a_r6_uflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    a_r6_uflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(pop_valid && !push_valid && ready));

    a_r3_spill_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_we) |-> $past(push_valid));
endmodule

bind spill_stack stk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_valid  (pop_valid),
    .ready      (ready),
    .underflow  (underflow),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack)
);

// File: tb/spill_stack_test.sv
`timescale 1ns/1ps
module spill_stack_test;
    localparam int W = 16, D = 4, LM = 2, AW = 8, BASE = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_valid = 1'b0, pop_valid = 1'b0;
    logic [W-1:0]  push_data = '0;
    logic [W-1:0]  pop_data;
    logic          ready, underflow, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;
    logic          mem_ack = 1'b0;
    logic [W-1:0]  mem_rdata = '0;

    always #2 clk = ~clk;

    spill_stack #(.DATA_W(W), .DEPTH(D), .LOW_MARK(LM), .ADDR_W(AW), .SPILL_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .pop_valid(pop_valid), .pop_data(pop_data), .ready(ready), .underflow(underflow),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int           vectors = 0, fails = 0;
    int           memreq_cycles = 0, writes_total = 0;
    logic [W-1:0] model[$];
    logic         model_uf = 1'b0;
    int           spill_q[$];
    logic [W-1:0] mem [256];

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference model
    initial forever begin
        @(negedge clk);
        #0.5;
        if (rst_n) begin
            check(underflow == model_uf, "R6 underflow flag", underflow, model_uf);
            if (mem_req) begin
                memreq_cycles++;
                check(!ready, "R5 ready low while busy", ready, 0);
            end
        end
    end

    // backing memory model, two cycles of latency
    initial begin
        bit           active = 0;
        int           lat = 0;
        logic [AW-1:0] cur_addr = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 1'b0;
                active  = 0;
            end else if (mem_ack) begin
                mem_ack = 1'b0;
                active  = 0;
            end else if (active) begin
                check(mem_req && mem_addr == cur_addr, "R9 request held", mem_addr, cur_addr);
                lat--;
                if (lat == 0) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem[cur_addr];
                end
            end else if (mem_req) begin
                active   = 1;
                lat      = 2;
                cur_addr = mem_addr;
                if (mem_we) begin
                    int exp_a;
                    exp_a = BASE + spill_q.size();
                    check(int'(mem_addr) == exp_a, "R3 spill address", mem_addr, exp_a);
                    mem[mem_addr] = mem_wdata;
                    spill_q.push_back(int'(mem_addr));
                    writes_total++;
                end else begin
                    int exp_a;
                    exp_a = (spill_q.size() > 0) ? spill_q[$] : -1;
                    check(int'(mem_addr) == exp_a, "R4 refill address", mem_addr, exp_a);
                    if (spill_q.size() > 0) void'(spill_q.pop_back());
                end
            end
        end
    end

    task automatic do_push(logic [W-1:0] v, bit also_pop);
        @(negedge clk);
        push_valid = 1'b1;
        pop_valid  = also_pop;
        push_data  = v;
        #1;
        while (!ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        model.push_back(v);
        #1;
        push_valid = 1'b0;
        pop_valid  = 1'b0;
    endtask

    task automatic do_pop(string tag);
        logic [W-1:0] exp;
        @(negedge clk);
        pop_valid = 1'b1;
        #1;
        while (!ready) begin
            @(negedge clk);
            #1;
        end
        exp = (model.size() > 0) ? model[$] : '0;
        check(pop_data == exp, tag, pop_data, exp);
        @(posedge clk);
        if (model.size() > 0) void'(model.pop_back());
        else                  model_uf = 1'b1;
        #1;
        pop_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: run hung actual=stalled expected=progress");
        summary();
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R7 reset state
        check(ready == 1'b1, "R7 ready after reset", ready, 1);
        check(underflow == 1'b0, "R7 underflow after reset", underflow, 0);
        check(mem_req == 1'b0, "R7 no request after reset", mem_req, 0);
        check(pop_data == '0, "R7 pop_data after reset", pop_data, 0);

        // R6 pop from an empty stack
        do_pop("R6 empty pop returns zero");
        repeat (2) @(negedge clk);

        // R2 and R1 inside the buffer
        base = memreq_cycles;
        for (int i = 0; i < D; i++) do_push(W'(16'h1000 + i), 1'b0);
        for (int i = 0; i < D; i++) do_pop("R1 LIFO within buffer");
        check(memreq_cycles == base, "R2 no memory traffic within buffer", memreq_cycles, base);

        // R3 spill, R4 refill
        for (int i = 0; i < 11; i++) do_push(W'(16'hA000 + i * 7), 1'b0);
        check(writes_total == 11 - D, "R3 spill count", writes_total, 11 - D);
        for (int i = 0; i < 11; i++) do_pop("R4 refilled LIFO data");
        check(spill_q.size() == 0, "R4 all spilled words restored", spill_q.size(), 0);

        // R8 both requests together
        do_push(16'h5A5A, 1'b0);
        do_push(16'hC3C3, 1'b1);
        do_pop("R8 push wins, newest word");
        do_pop("R8 push wins, older word kept");

        // mixed pattern crossing spill and refill repeatedly (R1)
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 7; i++) do_push(W'(r * 256 + i * 13 + 5), 1'b0);
            for (int i = 0; i < 3; i++) do_pop("R1 mixed pattern");
            for (int i = 0; i < 5; i++) do_push(W'(r * 512 + i * 3 + 1), 1'b0);
            for (int i = 0; i < 9; i++) do_pop("R1 mixed pattern");
        end
        while (model.size() > 0) do_pop("R1 drain");
        do_pop("R6 empty pop again returns zero");
        repeat (2) @(negedge clk);

        // R7 reset clears the sticky flag
        rst_n    = 1'b0;
        model_uf = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(underflow == 1'b0, "R7 underflow cleared by reset", underflow, 0);
        check(ready == 1'b1, "R7 ready after second reset", ready, 1);
        repeat (2) @(negedge clk);

        summary();
        $finish;
    end
endmodule